// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit

This block multiplies or divides two 32-bit integers, signed or unsigned, over several clock cycles. The multiply uses shift-and-add and the divide uses the restoring method. Both run on one shared adder/subtractor and one shift register, and each cycle performs one step. The result goes into two 32-bit result registers. For a multiply, `hi` holds the upper half of the 64-bit product and `lo` the lower half. For a divide, `hi` holds the remainder and `lo` the quotient.

Signed operations work on operand magnitudes and correct the signs in one fix-up cycle at the end. The unit raises no flag for overflow or for a zero divisor. A divide by zero finishes in the usual number of cycles and gives a fixed result, so software can detect it afterwards. A caller pulses `start` with an opcode and two operands while the unit is idle. It then waits for the one-cycle `done` pulse and reads `hi` and `lo`, which keep their values until the next operation completes.

Top module: `muldiv_seq`

## Requirements
- R1: While reset is active, and once it has been released, `busy`, `done`, `hi` and `lo` are all 0 until the first operation completes.
- R2: If `start` is high at a rising edge while `busy` is low, an operation begins and `busy` is high in the next cycle. If `start` is high while `busy` is high, it is ignored, and the running operation's result and timing do not change.
- R3: `done` is high for exactly one cycle. It rises W+1 cycles (33) after `busy` rises. `busy` falls in the same cycle, and `busy` and `done` are never high together.
- R4: Opcode 2'b01 (unsigned multiply) gives {`hi`,`lo`} equal to the 64-bit unsigned product of `opa` and `opb`.
- R5: Opcode 2'b00 (signed multiply) gives {`hi`,`lo`} equal to the 64-bit two's-complement product of `opa` and `opb`.
- R6: Opcode 2'b11 (unsigned divide) gives the quotient `opa`/`opb` in `lo` and the remainder in `hi`.
- R7: Opcode 2'b10 (signed divide) gives a quotient truncated toward zero in `lo`. The quotient is negated when the operand signs differ. The remainder in `hi` takes the sign of the dividend. The case -2^31 / -1 wraps to a quotient of 0x80000000 and a remainder of 0.
- R8: A divide by zero, signed or unsigned, gives `lo` = all ones and `hi` = `opa`.
- R9: `hi` and `lo` change only in the cycle in which `done` is high, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | Product upper half or remainder |
| lo | output | 32 | Product lower half or quotient |

## Verification
After the edge that accepts `start`, `busy` is due at once. Thirty-two step edges and one sign fix-up edge follow, and `done`, `hi` and `lo` are due together 33 cycles after `busy` rises. The bench drives inputs and samples outputs on falling edges. It counts the rising edges between acceptance and `done`, compares that count with 33, and compares the result registers in the `done` cycle. It checks again one cycle later that `done` has dropped and that `hi` and `lo` have not moved. It also pulses `start` again during some busy windows to show that the latency and the result do not change.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MULS = 2'b00,
    OP_MULU = 2'b01,
    OP_DIVS = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ITER = 2'b01,
    ST_FIX  = 2'b10
  } md_state_e;
endpackage

// File: rtl/md_sign_prep.sv
module md_sign_prep #(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_a,
  output logic         neg_b
);
  logic signed_op;

  always_comb begin
    // even opcodes are the signed variants
    signed_op = ~op[0];
    neg_a     = signed_op & opa[W-1];
    neg_b     = signed_op & opb[W-1];
    mag_a     = neg_a ? (~opa + 1'b1) : opa;
    mag_b     = neg_b ? (~opb + 1'b1) : opb;
  end
endmodule

// File: rtl/md_step.sv
module md_step #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] shr,
  input  logic [W-1:0] mreg,
  output logic [W-1:0] acc_nx,
  output logic [W-1:0] shr_nx
);
  localparam int AW = W + 1;
  localparam int SW = W + 2;

  logic [AW-1:0] a_in;
  logic [SW-1:0] b_ext;
  logic [SW-1:0] sum;
  logic [AW-1:0] kept;
  logic          borrow;

  // one shared adder: add for multiply, subtract for divide
  always_comb begin
    a_in   = is_div ? {acc, shr[W-1]} : {1'b0, acc};
    b_ext  = {2'b00, mreg};
    sum    = {1'b0, a_in} + (is_div ? ~b_ext : b_ext) + {{(SW-1){1'b0}}, is_div};
    borrow = sum[SW-1];
    if (is_div) begin
      // restoring step: on borrow keep the shifted remainder
      kept   = borrow ? a_in : sum[AW-1:0];
      acc_nx = kept[W-1:0];
      shr_nx = {shr[W-2:0], ~borrow};
    end else begin
      kept   = shr[0] ? sum[AW-1:0] : a_in;
      acc_nx = kept[AW-1:1];
      shr_nx = {kept[0], shr[W-1:1]};
    end
  end
endmodule

// File: rtl/md_sign_fix.sv
module md_sign_fix #(
  parameter int W = 32
) (
  input  logic         is_div,
  input  logic         neg_a,
  input  logic         neg_b,
  input  logic         div_zero,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] shr,
  output logic [W-1:0] hi_res,
  output logic [W-1:0] lo_res
);
  localparam int PW = 2 * W;

  logic [PW-1:0] prod;
  logic [PW-1:0] prod_s;
  logic [W-1:0]  quo_s;
  logic [W-1:0]  rem_s;
  logic          diff_sign;

  always_comb begin
    diff_sign = neg_a ^ neg_b;
    prod      = {acc, shr};
    prod_s    = diff_sign ? (~prod + 1'b1) : prod;
    quo_s     = (diff_sign && !div_zero) ? (~shr + 1'b1) : shr;
    rem_s     = neg_a ? (~acc + 1'b1) : acc;
    hi_res    = is_div ? rem_s : prod_s[PW-1:W];
    lo_res    = is_div ? quo_s : prod_s[W-1:0];
  end
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int            CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [1:0] rsync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_q_n = rsync[1];

  md_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  acc_q, acc_n;
  logic [W-1:0]  shr_q, shr_n;
  logic [W-1:0]  m_q, m_n;
  logic          isdiv_q, isdiv_n;
  logic          nega_q, nega_n;
  logic          negb_q, negb_n;
  logic          dz_q, dz_n;
  logic [W-1:0]  hi_q, hi_n;
  logic [W-1:0]  lo_q, lo_n;
  logic          done_q, done_n;

  logic [W-1:0]  mag_a, mag_b;
  logic          in_neg_a, in_neg_b;
  logic [W-1:0]  step_acc, step_shr;
  logic [W-1:0]  fix_hi, fix_lo;

  md_sign_prep #(.W(W)) u_prep (
    .op(op), .opa(opa), .opb(opb),
    .mag_a(mag_a), .mag_b(mag_b),
    .neg_a(in_neg_a), .neg_b(in_neg_b)
  );

  md_step #(.W(W)) u_step (
    .is_div(isdiv_q), .acc(acc_q), .shr(shr_q), .mreg(m_q),
    .acc_nx(step_acc), .shr_nx(step_shr)
  );

  md_sign_fix #(.W(W)) u_fix (
    .is_div(isdiv_q), .neg_a(nega_q), .neg_b(negb_q), .div_zero(dz_q),
    .acc(acc_q), .shr(shr_q),
    .hi_res(fix_hi), .lo_res(fix_lo)
  );

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    acc_n   = acc_q;
    shr_n   = shr_q;
    m_n     = m_q;
    isdiv_n = isdiv_q;
    nega_n  = nega_q;
    negb_n  = negb_q;
    dz_n    = dz_q;
    hi_n    = hi_q;
    lo_n    = lo_q;
    done_n  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_ITER;
          cnt_n   = '0;
          isdiv_n = op[1];
          nega_n  = in_neg_a;
          negb_n  = in_neg_b;
          dz_n    = (opb == '0);
          acc_n   = '0;
          shr_n   = op[1] ? mag_a : mag_b;
          m_n     = op[1] ? mag_b : mag_a;
        end
      end
      ST_ITER: begin
        acc_n = step_acc;
        shr_n = step_shr;
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == LAST) state_n = ST_FIX;
      end
      ST_FIX: begin
        hi_n    = fix_hi;
        lo_n    = fix_lo;
        done_n  = 1'b1;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      acc_q   <= '0;
      shr_q   <= '0;
      m_q     <= '0;
      isdiv_q <= 1'b0;
      nega_q  <= 1'b0;
      negb_q  <= 1'b0;
      dz_q    <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      acc_q   <= acc_n;
      shr_q   <= shr_n;
      m_q     <= m_n;
      isdiv_q <= isdiv_n;
      nega_q  <= nega_n;
      negb_q  <= negb_n;
      dz_q    <= dz_n;
      hi_q    <= hi_n;
      lo_q    <= lo_n;
      done_q  <= done_n;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;
  assign hi   = hi_q;
  assign lo   = lo_q;
endmodule

// File: rtl/md_checker.sv
module md_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  localparam int BW  = $clog2(W + 2) + 1;
  localparam int LAT = W + 1;

  logic [BW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bcnt == BW'(LAT)));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi) && $stable(lo)));
endmodule

bind muldiv_seq md_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .start(start), .busy(busy),
  .done(done), .hi(hi), .lo(lo)
);

// File: tb/tb_muldiv_seq.sv
`timescale 1ns/1ps
module tb_muldiv_seq;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [31:0] opa, opb;
  logic        busy, done;
  logic [31:0] hi, lo;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  muldiv_seq #(.W(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .opa(opa), .opb(opb), .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary_and_end();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog: run exceeded cycle limit");
      summary_and_end();
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(logic [1:0] o, logic [31:0] a, logic [31:0] b);
    longint sa, sb, q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (o)
      2'b00: return 64'(sa * sb);
      2'b01: return {32'b0, a} * {32'b0, b};
      2'b10: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  function automatic string rq(logic [1:0] o, logic [31:0] b);
    if (o[1] && b == 0) return "R8";
    case (o)
      2'b00:   return "R5";
      2'b01:   return "R4";
      2'b10:   return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(logic [1:0] o, logic [31:0] a, logic [31:0] b, bit disturb);
    logic [63:0] exp;
    int lat;
    exp = model(o, a, b);
    @(negedge clk);
    start = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    // R2 accepted: busy due the cycle after the start edge
    chk("R2 busy after start", {63'b0, busy}, 64'd1);
    lat = 0;
    while (!done && lat < 100) begin
      if (disturb && lat == 5) begin
        start = 1'b1; op = ~o; opa = ~a; opb = b + 32'd3;
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    // R3 latency measured in cycles from busy rising
    chk("R3 latency", 64'(lat), 64'd33);
    chk("R3 busy low with done", {63'b0, busy}, 64'd0);
    chk(disturb ? "R2 ignored start, result" : rq(o, b), {hi, lo}, exp);
    @(negedge clk);
    chk("R3 done single cycle", {63'b0, done}, 64'd0);
    // R9 result holds after done
    chk("R9 hold", {hi, lo}, exp);
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] v;
    v = $urandom;
    case ($urandom_range(0, 9))
      0: v = 32'h0;
      1: v = 32'h1;
      2: v = 32'hFFFF_FFFF;
      3: v = 32'h8000_0000;
      4: v = 32'h7FFF_FFFF;
      5: v = v & 32'h0000_00FF;
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    void'($urandom(32'd20240917));
    rst_n = 1'b0; start = 1'b0; op = 2'b00; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {62'b0, busy, done}, 64'd0);
    chk("R1 reset result", {hi, lo}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {30'b0, busy, done, hi}, 64'd0);

    // directed corners
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0); // R4
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0); // R5
    run_op(2'b00, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0); // R5
    run_op(2'b00, 32'h0000_1234, 32'hFFFF_FFF0, 1'b0); // R5
    run_op(2'b11, 32'd100, 32'd7, 1'b0);               // R6
    run_op(2'b11, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0); // R6
    run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 1'b0);         // R7 -7/2
    run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 1'b0);         // R7 7/-2
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0); // R7 wrap
    run_op(2'b10, 32'd0, 32'd5, 1'b0);                 // R7
    run_op(2'b11, 32'hDEAD_BEEF, 32'd0, 1'b0);         // R8
    run_op(2'b10, 32'hFFFF_FFFB, 32'd0, 1'b0);         // R8 signed
    run_op(2'b01, 32'd12345, 32'd678, 1'b1);           // R2 disturbed
    run_op(2'b10, 32'hFFFF_0000, 32'd3, 1'b1);         // R2 disturbed

    for (int i = 0; i < 300; i++) begin
      run_op(2'($urandom_range(0, 3)), pick(), pick(), ($urandom_range(0, 7) == 0));
    end

    // R9 hold over an idle stretch
    begin
      logic [63:0] snap;
      snap = {hi, lo};
      repeat (10) @(negedge clk);
      chk("R9 idle hold", {hi, lo}, snap);
    end
    summary_and_end();
  end
endmodule